// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Unit

This unit keeps the five machine-level control and status registers a small in-order processor core needs for trap handling: an interrupt-enable mask, the trap handler base address, a scratch word, the saved exception program counter and the trap cause. The core presents a 12-bit register address together with a 3-bit operation code, a register operand and an immediate operand. The unit returns the addressed register's current contents at once, and on the next rising clock edge it stores the result of a write, set-bits or clear-bits operation.

When the core takes a trap it raises a strobe for one cycle. The unit then saves the current program counter and the supplied cause code. The trap save has priority over a software write to either of those two registers in the same cycle. The interrupt-enable mask, the handler address and the saved program counter also drive dedicated output ports, so that fetch and interrupt logic can use them without a read cycle.

Top module: `mcsr_unit`

## Requirements
- R1: A synchronous active-low reset clears all five registers to zero, and so also every exposed output and every read.
- R2: Operation code 3'b001 stores the register operand and 3'b101 stores the immediate operand into the addressed register at the next rising edge. A read of that address returns the new value from the cycle after the edge.
- R3: Operation codes 3'b010 (register operand) and 3'b110 (immediate operand) store the bitwise OR of the operand with the register's current contents.
- R4: Operation codes 3'b011 (register operand) and 3'b111 (immediate operand) store the current contents ANDed with the inverted operand.
- R5: Operation codes 3'b000 and 3'b100 never change a register, even with the write enable high.
- R6: Read data is combinational from the address. The register addresses are 0x304 interrupt enable, 0x305 handler base, 0x340 scratch, 0x341 exception PC and 0x342 cause. Any other address reads zero, and writes to it change nothing.
- R7: With the trap strobe high at a rising edge, the exception PC register loads the current PC and the cause register loads the trap cause input.
- R8: If a trap and a software write to the exception PC or cause register fall in the same cycle, the trap values are stored.
- R9: Each exposed output holds its value unless its own address is written. The exception PC output may also change on a trap.
- R10: Writes on consecutive cycles to one register are applied in order, each operating on the result of the previous one.
- R11: With the write enable low, no register changes except through a trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_addr | input | 12 | Register address |
| csr_op | input | 3 | Operation code |
| reg_operand | input | 32 | Operand from the register file |
| imm_operand | input | 32 | Zero-extended immediate operand |
| wr_en | input | 1 | Performs the operation at the next edge |
| cur_pc | input | 32 | Program counter of the current instruction |
| trap_strobe | input | 1 | Trap taken this cycle |
| trap_cause | input | 32 | Cause code to save on a trap |
| rd_data | output | 32 | Current contents of the addressed register |
| irq_enable | output | 32 | Interrupt-enable mask |
| trap_vector | output | 32 | Trap handler base address |
| exc_pc | output | 32 | Saved exception program counter |

## Verification
The read port has no latency. Every stored effect, whether a write, a set, a clear, a trap save or a reset, appears exactly one rising edge after the cycle that requests it. The bench drives inputs on the falling edge and lets one rising edge pass. At the next falling edge it drops the write enable and the trap strobe, then samples the outputs, so each check sees the result of exactly one edge. Back-to-back writes are sampled at each intermediate falling edge while the write enable is still asserted, which shows that each operation reads the value left by the one before.

// File: rtl/mcsr_pkg.sv
// Shared constants for the machine-mode register unit.
// Assumes a 32-bit datapath and the standard 12-bit register address space.
package mcsr_pkg;
    localparam int XLEN     = 32;
    localparam int ADDR_W   = 12;
    localparam int NUM_REGS = 5;

    // Register slots, in storage order
    localparam int IDX_IE    = 0;
    localparam int IDX_TVEC  = 1;
    localparam int IDX_SCR   = 2;
    localparam int IDX_EPC   = 3;
    localparam int IDX_CAUSE = 4;

    // Operation codes: bit 2 selects the immediate, bits 1:0 pick the function
    typedef enum logic [2:0] {
        OP_NOP0 = 3'b000,
        OP_WR   = 3'b001,
        OP_SET  = 3'b010,
        OP_CLR  = 3'b011,
        OP_NOP4 = 3'b100,
        OP_WRI  = 3'b101,
        OP_SETI = 3'b110,
        OP_CLRI = 3'b111
    } csr_op_e;

    // Address of each register slot
    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            IDX_IE:    slot_addr = 12'h304;
            IDX_TVEC:  slot_addr = 12'h305;
            IDX_SCR:   slot_addr = 12'h340;
            IDX_EPC:   slot_addr = 12'h341;
            IDX_CAUSE: slot_addr = 12'h342;
            default:   slot_addr = '0;
        endcase
    endfunction
endpackage

// File: rtl/mcsr_alu.sv
// Read-modify-write datapath: forms the value to store from the current
// contents and the selected operand. Purely combinational.
// Assumes the caller supplies the addressed register's current contents.
module mcsr_alu
    import mcsr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] reg_opnd,
    input  logic [W-1:0] imm_opnd,
    output logic [W-1:0] new_val,
    output logic         does_write
);
    logic [W-1:0] opnd;

    // Pick the operand and apply the write, set or clear function
    always_comb begin
        opnd       = op[2] ? imm_opnd : reg_opnd;
        does_write = (op[1:0] != 2'b00);
        case (op[1:0])
            2'b01:   new_val = opnd;
            2'b10:   new_val = cur_val | opnd;
            2'b11:   new_val = cur_val & ~opnd;
            default: new_val = cur_val;
        endcase
    end
endmodule

// File: rtl/mcsr_decode.sv
// Address decoder: one select line per register slot.
// Assumes the slot addresses are distinct, so at most one line is high.
module mcsr_decode
    import mcsr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int N  = NUM_REGS
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel
);
    // One comparator per slot
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign sel[i] = (addr == slot_addr(i));
    end
endmodule

// File: rtl/mcsr_reg.sv
// One register slot with synchronous active-low clear. When HAS_TRAP is set,
// a trap load has priority over a software write.
// Assumes wr_sel is already qualified by the write enable and the operation code.
module mcsr_reg #(
    parameter int W        = 32,
    parameter bit HAS_TRAP = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_val,
    input  logic         trap_ld,
    input  logic [W-1:0] trap_val,
    output logic [W-1:0] q
);
    logic take_trap;
    assign take_trap = HAS_TRAP && trap_ld;

    // Storage: clear, then trap load, then software write
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (take_trap) q <= trap_val;
        else if (wr_sel)    q <= wr_val;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R9
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && !take_trap) |=> $stable(q));

    // R7
    trap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> q == $past(trap_val));

    // R2
    write_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !take_trap) |=> q == $past(wr_val));
endmodule

// File: rtl/mcsr_unit.sv
// Machine-mode control and status register unit. Decodes the address, reads
// the slot combinationally, computes the read-modify-write value and stores it
// on the next edge. A trap saves the PC and the cause and overrides a write.
// Assumes one operation per cycle, with the trap strobe high for one cycle per trap.
module mcsr_unit
    import mcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [2:0]        csr_op,
    input  logic [XLEN-1:0]   reg_operand,
    input  logic [XLEN-1:0]   imm_operand,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              trap_strobe,
    input  logic [XLEN-1:0]   trap_cause,
    output logic [XLEN-1:0]   rd_data,
    output logic [XLEN-1:0]   irq_enable,
    output logic [XLEN-1:0]   trap_vector,
    output logic [XLEN-1:0]   exc_pc
);
    logic [NUM_REGS-1:0] sel;
    logic [NUM_REGS-1:0] wsel;
    logic [XLEN-1:0]     slot_q    [NUM_REGS];
    logic [XLEN-1:0]     slot_trap [NUM_REGS];
    logic [XLEN-1:0]     masked    [NUM_REGS];
    logic [XLEN-1:0]     new_val;
    logic                does_write;

    mcsr_decode #(.AW(ADDR_W), .N(NUM_REGS)) u_dec (
        .addr (csr_addr),
        .sel  (sel)
    );

    mcsr_alu #(.W(XLEN)) u_alu (
        .op         (csr_op),
        .cur_val    (rd_data),
        .reg_opnd   (reg_operand),
        .imm_opnd   (imm_operand),
        .new_val    (new_val),
        .does_write (does_write)
    );

    // One slot per register; only the exception PC and cause take trap loads
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam bit TRAPS = (i == IDX_EPC) || (i == IDX_CAUSE);
        assign wsel[i]      = wr_en & does_write & sel[i];
        assign slot_trap[i] = (i == IDX_EPC) ? cur_pc : trap_cause;
        assign masked[i]    = sel[i] ? slot_q[i] : '0;

        mcsr_reg #(.W(XLEN), .HAS_TRAP(TRAPS)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wsel[i]),
            .wr_val   (new_val),
            .trap_ld  (trap_strobe),
            .trap_val (slot_trap[i]),
            .q        (slot_q[i])
        );
    end

    // Read mux: OR of the selected slots, zero when no slot matches
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) rd_data = rd_data | masked[i];
    end

    assign irq_enable  = slot_q[IDX_IE];
    assign trap_vector = slot_q[IDX_TVEC];
    assign exc_pc      = slot_q[IDX_EPC];

    // R8
    trap_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_strobe && wr_en && sel[IDX_EPC]) |=> exc_pc == $past(cur_pc));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !trap_strobe) |=> ($stable(irq_enable) && $stable(trap_vector) && $stable(exc_pc)));

    // R6
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> rd_data == '0);
endmodule

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;
    import mcsr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] csr_addr;
    logic [2:0]  csr_op;
    logic [31:0] reg_operand, imm_operand, cur_pc, trap_cause;
    logic        wr_en, trap_strobe;
    logic [31:0] rd_data, irq_enable, trap_vector, exc_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mcsr_unit u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_op(csr_op),
        .reg_operand(reg_operand), .imm_operand(imm_operand), .wr_en(wr_en),
        .cur_pc(cur_pc), .trap_strobe(trap_strobe), .trap_cause(trap_cause),
        .rd_data(rd_data), .irq_enable(irq_enable), .trap_vector(trap_vector),
        .exc_pc(exc_pc)
    );

    typedef struct packed {
        logic [11:0] a;
        logic [2:0]  op;
        logic [31:0] rs;
        logic [31:0] im;
        logic [31:0] ex;
        logic [7:0]  rq;
    } vec_t;

    // One write per entry; ex is the value read back at the same address afterwards
    localparam vec_t TBL [0:12] = '{
        '{12'h340, 3'b001, 32'hA5A5_0F0F, 32'h0,         32'hA5A5_0F0F, 8'd2}, // R2
        '{12'h340, 3'b010, 32'h0000_F0F0, 32'h0,         32'hA5A5_FFFF, 8'd3}, // R3
        '{12'h340, 3'b011, 32'hA5A5_0000, 32'h0,         32'h0000_FFFF, 8'd4}, // R4
        '{12'h340, 3'b101, 32'hFFFF_FFFF, 32'h0000_001F, 32'h0000_001F, 8'd2}, // R2
        '{12'h340, 3'b110, 32'hFFFF_FFFF, 32'h0000_0100, 32'h0000_011F, 8'd3}, // R3
        '{12'h340, 3'b111, 32'h0,         32'h0000_0003, 32'h0000_011C, 8'd4}, // R4
        '{12'h340, 3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_011C, 8'd5}, // R5
        '{12'h340, 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_011C, 8'd5}, // R5
        '{12'h304, 3'b001, 32'h0000_0888, 32'h0,         32'h0000_0888, 8'd2}, // R2
        '{12'h305, 3'b001, 32'h8000_0100, 32'h0,         32'h8000_0100, 8'd2}, // R2
        '{12'h341, 3'b001, 32'h0000_1000, 32'h0,         32'h0000_1000, 8'd2}, // R2
        '{12'h342, 3'b110, 32'h0,         32'h0000_000B, 32'h0000_000B, 8'd3}, // R3
        '{12'h7C0, 3'b001, 32'hFFFF_FFFF, 32'h0,         32'h0000_0000, 8'd6}  // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive one operation, let one edge pass, then drop the strobes and settle
    task automatic do_op(input logic [11:0] a, input logic [2:0] op,
                         input logic [31:0] rs, input logic [31:0] im,
                         input logic we, input logic tr);
        @(negedge clk);
        csr_addr = a; csr_op = op; reg_operand = rs; imm_operand = im;
        wr_en = we; trap_strobe = tr;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; trap_strobe = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; csr_addr = 12'h340; csr_op = 3'b000; reg_operand = '0;
        imm_operand = '0; wr_en = 1'b0; trap_strobe = 1'b0;
        cur_pc = '0; trap_cause = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1: reset state
        check("R1 irq_enable", irq_enable, 32'h0);
        check("R1 trap_vector", trap_vector, 32'h0);
        check("R1 exc_pc", exc_pc, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);

        // Vector table
        for (int i = 0; i <= 12; i++) begin
            do_op(TBL[i].a, TBL[i].op, TBL[i].rs, TBL[i].im, 1'b1, 1'b0);
            check($sformatf("R%0d vector %0d", TBL[i].rq, i), rd_data, TBL[i].ex);
        end
        check("R2 irq_enable port", irq_enable, 32'h0000_0888);
        check("R2 trap_vector port", trap_vector, 32'h8000_0100);
        check("R2 exc_pc port", exc_pc, 32'h0000_1000);

        // R6: unmapped write left the scratch register alone
        csr_addr = 12'h340; #1;
        check("R6 scratch after unmapped write", rd_data, 32'h0000_011C);

        // R11: write enable low changes nothing
        do_op(12'h304, 3'b001, 32'h1, 32'h0, 1'b0, 1'b0);
        check("R11 irq_enable", irq_enable, 32'h0000_0888);
        check("R11 read", rd_data, 32'h0000_0888);

        // R9: a scratch write leaves the exposed registers untouched
        do_op(12'h340, 3'b001, 32'hDEAD_BEEF, 32'h0, 1'b1, 1'b0);
        check("R9 irq_enable", irq_enable, 32'h0000_0888);
        check("R9 trap_vector", trap_vector, 32'h8000_0100);
        check("R9 exc_pc", exc_pc, 32'h0000_1000);

        // R7: trap saves PC and cause
        cur_pc = 32'h0000_2000; trap_cause = 32'h8000_000B;
        do_op(12'h304, 3'b000, 32'h0, 32'h0, 1'b0, 1'b1);
        check("R7 exc_pc", exc_pc, 32'h0000_2000);
        csr_addr = 12'h342; #1;
        check("R7 cause", rd_data, 32'h8000_000B);
        check("R9 trap_vector after trap", trap_vector, 32'h8000_0100);

        // R8: trap wins over a same-cycle write to each trap register
        cur_pc = 32'h0000_3000; trap_cause = 32'h0000_0007;
        do_op(12'h341, 3'b001, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1);
        check("R8 exc_pc", exc_pc, 32'h0000_3000);
        cur_pc = 32'h0000_3004; trap_cause = 32'h0000_0002;
        do_op(12'h342, 3'b001, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1);
        check("R8 cause", rd_data, 32'h0000_0002);

        // R10: back-to-back writes, each sampled before the next edge
        @(negedge clk);
        csr_addr = 12'h340; csr_op = 3'b001; reg_operand = 32'h10; wr_en = 1'b1;
        @(negedge clk); #1;
        check("R10 step1", rd_data, 32'h10);
        csr_op = 3'b010; reg_operand = 32'h3;
        @(negedge clk); #1;
        check("R10 step2", rd_data, 32'h13);
        csr_op = 3'b011; reg_operand = 32'h1;
        @(negedge clk); wr_en = 1'b0; #1;
        check("R10 step3", rd_data, 32'h12);

        // R1: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 irq_enable after reset", irq_enable, 32'h0);
        check("R1 trap_vector after reset", trap_vector, 32'h0);
        check("R1 exc_pc after reset", exc_pc, 32'h0);
        check("R1 scratch after reset", rd_data, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule